// File: doc/BRIEF.md
# External Bus Page-Access Sequencer

This block converts internal bus requests into external memory cycles framed by an active-low chip-select. A request is a single transfer or a line-fill burst of 1, 2, 4 or 8 transfers of 1, 2 or 4 bytes. When a transfer is wider than the external data bus (8 or 16 bits), each transfer is split into several external beats. Beats that fall inside the same programmable page are merged into one page-mode access, with chip-select held low, as long as page mode is enabled for the access direction. When the next beat's address leaves the page, chip-select is released and a new access begins.

Every access opens with one setup cycle. Each beat then takes a programmable number of wait cycles and one strobe cycle. After the last beat of an access, chip-select stays low for a programmable delay. Reads with a zero delay still spend one sample cycle before the next access may begin. Read data comes back beat by beat with a valid strobe. Write data is taken from a word supplied by the requester, and the block pulses a pop signal to advance that word. A one-cycle done pulse closes each request.

Top module: `ext_page_seq`

## Requirements
- R1: After reset, ext_cs_n, ext_rd_n and ext_wr_n are 1, req_ready is 1 and done is 0.
- R2: A request with req_size s (0/1/2 = 1/2/4 bytes), req_len_log2 L and bus width b (cfg_bus16 0 = 8-bit, 1 = 16-bit) makes 2^(L+s-m) external beats, where m = min(s, cfg_bus16). With req_wrap = 0, beat k presents the address req_addr + k·2^m.
- R3: With req_wrap = 1, beat addresses advance by 2^m but stay inside the block of 2^(L+s) bytes aligned around req_addr, wrapping from its top back to its base.
- R4: When page mode is enabled for the direction (cfg_page_rd_en for reads, cfg_page_wr_en for writes) and there is more than one beat, consecutive beats whose addresses share a page of 16·2^cfg_page_sel bytes are served inside one low interval of ext_cs_n.
- R5: When the next beat's address lies in a different page, ext_cs_n returns high and a new access with its own setup cycle begins. This applies in both increment and wrap modes.
- R6: With page mode disabled for the direction, every beat is a separate access with its own chip-select low interval.
- R7: Each access starts with one setup cycle with ext_cs_n high. Each beat then has cfg_wait wait cycles and one strobe cycle (ext_rd_n or ext_wr_n low) with ext_cs_n low.
- R8: After the last strobe of an access, ext_cs_n stays low for cfg_cs_delay cycles, and the next access or idle follows at once. A read with cfg_cs_delay = 0 adds one sample cycle with ext_cs_n high. A busy request therefore lasts accesses·(1+g) + beats·(cfg_wait+1) cycles, where g = cfg_cs_delay, or 1 for a read with zero delay.
- R9: One cycle after each read strobe, rd_valid is 1 and rd_data equals ext_rdata as sampled at the end of that strobe cycle, in beat order.
- R10: During a write strobe, ext_wdata holds wr_word shifted right by 8·(address mod transfer bytes). wr_pop is 1 during the strobe of the last beat of each transfer.
- R11: req_ready is 0 in every busy cycle. done is 1 for exactly one cycle, the first idle cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | AW | Start byte address, aligned to the transfer size |
| req_size | input | 2 | Transfer size: 0 byte, 1 half, 2 word |
| req_len_log2 | input | LEN_W | Log2 of the transfer count |
| req_wrap | input | 1 | 1 = wrap burst, 0 = increment |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_word | input | 32 | Write data of the current transfer |
| wr_pop | output | 1 | Current transfer's write data consumed |
| cfg_bus16 | input | 1 | External bus width: 0 = 8-bit, 1 = 16-bit |
| cfg_page_sel | input | 2 | Page size 16·2^n bytes |
| cfg_wait | input | WAIT_W | Wait cycles per beat |
| cfg_cs_delay | input | DLY_W | Chip-select hold cycles after the last strobe |
| cfg_page_rd_en | input | 1 | Page mode for reads |
| cfg_page_wr_en | input | 1 | Page mode for writes |
| ext_cs_n | output | 1 | Chip-select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_addr | output | AW | External byte address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | 16 | Read beat data |
| done | output | 1 | Request complete pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 2-bit length field (bursts up to 8 transfers) and 4-bit wait and delay fields. It sweeps every combination of bus width, transfer size, burst length, wrap mode and direction under four timing and page settings. These settings put page breaks at 16- and 32-byte boundaries and cover zero and non-zero chip-select delays for both reads and writes. Beat addresses, access counts, busy cycle counts, read data and write byte lanes are all predicted arithmetically from the requirement formulas.

// File: rtl/epg_pkg.sv
package epg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_STROBE,
    ST_TAIL,
    ST_SAMPLE
  } epg_state_e;

  localparam int EPG_WORD_W = 32;
  localparam int EPG_EXT_W  = 16;

  function automatic logic [1:0] epg_min_log2(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/epg_cycle_cnt.sv
module epg_cycle_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/epg_addr_step.sv
module epg_addr_step #(
  parameter int AW   = 16,
  parameter int TL_W = 3
) (
  input  logic [AW-1:0]   cur_addr,
  input  logic [1:0]      size_log2,
  input  logic [1:0]      beat_log2,
  input  logic [TL_W-1:0] total_log2,
  input  logic            wrap,
  input  logic [1:0]      page_sel,
  output logic [AW-1:0]   nxt_addr,
  output logic            page_cross,
  output logic            xfer_last
);
  logic [AW-1:0] step;
  logic [AW-1:0] incr;
  logic [AW-1:0] wmask;
  logic [AW-1:0] smask;
  logic [AW-1:0] cur_pg;
  logic [AW-1:0] nxt_pg;

  always_comb begin
    step     = AW'(1) << beat_log2;
    incr     = cur_addr + step;
    wmask    = (AW'(1) << total_log2) - AW'(1);
    smask    = (AW'(1) << size_log2) - AW'(1);
    nxt_addr = wrap ? ((cur_addr & ~wmask) | (incr & wmask)) : incr;
    cur_pg   = cur_addr >> (3'd4 + {1'b0, page_sel});
    nxt_pg   = nxt_addr >> (3'd4 + {1'b0, page_sel});
    page_cross = (cur_pg != nxt_pg);
    xfer_last  = (((cur_addr & smask) + step) & smask) == '0;
  end
endmodule

// File: rtl/ext_page_seq.sv
module ext_page_seq
  import epg_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LEN_W  = 2,
  parameter int WAIT_W = 4,
  parameter int DLY_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic [LEN_W-1:0]      req_len_log2,
  input  logic                  req_wrap,
  input  logic                  req_write,
  input  logic [EPG_WORD_W-1:0] wr_word,
  output logic                  wr_pop,
  input  logic                  cfg_bus16,
  input  logic [1:0]            cfg_page_sel,
  input  logic [WAIT_W-1:0]     cfg_wait,
  input  logic [DLY_W-1:0]      cfg_cs_delay,
  input  logic                  cfg_page_rd_en,
  input  logic                  cfg_page_wr_en,
  output logic                  ext_cs_n,
  output logic                  ext_rd_n,
  output logic                  ext_wr_n,
  output logic [AW-1:0]         ext_addr,
  output logic [EPG_EXT_W-1:0]  ext_wdata,
  input  logic [EPG_EXT_W-1:0]  ext_rdata,
  output logic                  rd_valid,
  output logic [EPG_EXT_W-1:0]  rd_data,
  output logic                  done
);
  localparam int MAXLOG = (1 << LEN_W) - 1 + 2;
  localparam int BEAT_W = MAXLOG + 1;
  localparam int TL_W   = $clog2(MAXLOG + 1);
  localparam int CNT_W  = (WAIT_W > DLY_W) ? WAIT_W : DLY_W;

  // request decode
  logic [1:0]      sz_in;
  logic [1:0]      bb_in;
  logic [TL_W-1:0] tl_in;
  logic [TL_W-1:0] nbl_in;
  logic [BEAT_W-1:0] beats_in;
  logic            page_ok_in;

  always_comb begin
    sz_in      = (req_size > 2'd2) ? 2'd2 : req_size;
    bb_in      = epg_min_log2(sz_in, {1'b0, cfg_bus16});
    tl_in      = TL_W'(req_len_log2) + TL_W'(sz_in);
    nbl_in     = tl_in - TL_W'(bb_in);
    beats_in   = BEAT_W'(1) << nbl_in;
    page_ok_in = (req_write ? cfg_page_wr_en : cfg_page_rd_en) && (nbl_in != '0);
  end

  // transaction state
  epg_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [1:0]        sz_q;
  logic [1:0]        bb_q;
  logic [TL_W-1:0]   tl_q;
  logic              wrap_q;
  logic              write_q;
  logic              page_ok_q;
  logic [BEAT_W-1:0] beats_q;

  logic [AW-1:0]     nxt_addr;
  logic              page_cross;
  logic              xfer_last;

  epg_addr_step #(.AW(AW), .TL_W(TL_W)) u_step (
    .cur_addr  (addr_q),
    .size_log2 (sz_q),
    .beat_log2 (bb_q),
    .total_log2(tl_q),
    .wrap      (wrap_q),
    .page_sel  (cfg_page_sel),
    .nxt_addr  (nxt_addr),
    .page_cross(page_cross),
    .xfer_last (xfer_last)
  );

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  epg_cycle_cnt #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .zero    (cnt_zero)
  );

  // next-state logic
  logic wait_nz;
  logic dly_nz;
  logic last_beat;

  always_comb begin
    wait_nz   = (cfg_wait != '0);
    dly_nz    = (cfg_cs_delay != '0);
    last_beat = (beats_q == BEAT_W'(1));
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d  = wait_nz ? ST_WAIT : ST_STROBE;
        cnt_load = wait_nz;
        cnt_val  = CNT_W'(cfg_wait) - 1'b1;
      end
      ST_WAIT: begin
        if (cnt_zero) state_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (!last_beat && page_ok_q && !page_cross) begin
          state_d  = wait_nz ? ST_WAIT : ST_STROBE;
          cnt_load = wait_nz;
          cnt_val  = CNT_W'(cfg_wait) - 1'b1;
        end else if (dly_nz) begin
          state_d  = ST_TAIL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(cfg_cs_delay) - 1'b1;
        end else if (!write_q) begin
          state_d = ST_SAMPLE;
        end else begin
          state_d = last_beat ? ST_IDLE : ST_SETUP;
        end
      end
      ST_TAIL: begin
        if (cnt_zero) state_d = (beats_q != '0) ? ST_SETUP : ST_IDLE;
      end
      ST_SAMPLE: begin
        state_d = (beats_q != '0) ? ST_SETUP : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      sz_q      <= '0;
      bb_q      <= '0;
      tl_q      <= '0;
      wrap_q    <= 1'b0;
      write_q   <= 1'b0;
      page_ok_q <= 1'b0;
      beats_q   <= '0;
      ext_cs_n  <= 1'b1;
      ext_rd_n  <= 1'b1;
      ext_wr_n  <= 1'b1;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q    <= req_addr;
        sz_q      <= sz_in;
        bb_q      <= bb_in;
        tl_q      <= tl_in;
        wrap_q    <= req_wrap;
        write_q   <= req_write;
        page_ok_q <= page_ok_in;
        beats_q   <= beats_in;
      end
      if (state_q == ST_STROBE) begin
        beats_q <= beats_q - 1'b1;
        if (!last_beat) addr_q <= nxt_addr;
      end
      ext_cs_n <= !(state_d == ST_WAIT || state_d == ST_STROBE || state_d == ST_TAIL);
      ext_rd_n <= !(state_d == ST_STROBE && !write_q);
      ext_wr_n <= !(state_d == ST_STROBE && write_q);
      rd_valid <= (state_q == ST_STROBE) && !write_q;
      done     <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_STROBE && !write_q) rd_data <= ext_rdata;
  end

  // write lane select
  logic [1:0] lane_off;

  always_comb begin
    lane_off = addr_q[1:0] & ((sz_q == 2'd2) ? 2'd3 : (sz_q == 2'd1) ? 2'd1 : 2'd0);
    unique case (lane_off)
      2'd0:    ext_wdata = wr_word[15:0];
      2'd1:    ext_wdata = wr_word[23:8];
      2'd2:    ext_wdata = wr_word[31:16];
      default: ext_wdata = {8'h00, wr_word[31:24]};
    endcase
  end

  assign wr_pop    = (state_q == ST_STROBE) && write_q && xfer_last;
  assign req_ready = (state_q == ST_IDLE);
  assign ext_addr  = addr_q;
endmodule

// File: rtl/epg_checker.sv
module epg_checker (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic ext_cs_n,
  input logic ext_rd_n,
  input logic ext_wr_n,
  input logic rd_valid,
  input logic wr_pop
);
  a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ext_cs_n && ext_rd_n && ext_wr_n));

  a_r7_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !ext_cs_n);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r5_setup_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_cs_n) |-> !$past(req_ready));

  a_r9_rdvalid_follows: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |=> rd_valid);

  a_r10_pop_write: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> !ext_wr_n);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);
endmodule

bind ext_page_seq epg_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .done     (done),
  .ext_cs_n (ext_cs_n),
  .ext_rd_n (ext_rd_n),
  .ext_wr_n (ext_wr_n),
  .rd_valid (rd_valid),
  .wr_pop   (wr_pop)
);

// File: tb/ext_page_seq_test.sv
module ext_page_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_len_log2 = '0;
  logic        req_wrap = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] wr_word = '0;
  logic        wr_pop;
  logic        cfg_bus16 = 1'b0;
  logic [1:0]  cfg_page_sel = '0;
  logic [3:0]  cfg_wait = '0;
  logic [3:0]  cfg_cs_delay = '0;
  logic        cfg_page_rd_en = 1'b0;
  logic        cfg_page_wr_en = 1'b0;
  logic        ext_cs_n, ext_rd_n, ext_wr_n;
  logic [15:0] ext_addr, ext_wdata, ext_rdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, ~a[7:0]};
  endfunction

  function automatic logic [31:0] word_f(input int t);
    return 32'h8C4E1A2B ^ (32'(t) * 32'h11111111);
  endfunction

  function automatic logic [15:0] beat_addr(input logic [15:0] base, input int k,
                                            input int bbl, input int tl, input int wrap);
    logic [15:0] step, mask;
    step = 16'(k) << bbl;
    if (wrap == 0) return base + step;
    mask = (16'd1 << tl) - 16'd1;
    return (base & ~mask) | ((base + step) & mask);
  endfunction

  assign ext_rdata = mem_f(ext_addr);

  ext_page_seq uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_len_log2(req_len_log2), .req_wrap(req_wrap),
    .req_write(req_write), .wr_word(wr_word), .wr_pop(wr_pop),
    .cfg_bus16(cfg_bus16), .cfg_page_sel(cfg_page_sel), .cfg_wait(cfg_wait),
    .cfg_cs_delay(cfg_cs_delay), .cfg_page_rd_en(cfg_page_rd_en),
    .cfg_page_wr_en(cfg_page_wr_en),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic run_txn(input int size, input int len, input int wrap, input int wr,
                         input int bus, input int psel, input int w, input int d,
                         input int pr, input int pw, input logic [15:0] base_in);
    int sb, bbl, nbl, nb, tl, pok, acc, gap, expcyc;
    int k, r, pops, falls, cyc, busy_bad;
    int addr_bad, rd_bad, wd_bad;
    logic [15:0] base, ea, wexp, wmask, bad_a, bad_e;
    logic prev_cs;
    string tag_acc, tag_cyc, tag_adr;
    sb   = 1 << size;
    bbl  = (size < bus) ? size : bus;
    nbl  = len + size - bbl;
    nb   = 1 << nbl;
    tl   = len + size;
    base = base_in & ~16'(sb - 1);
    pok  = ((wr != 0 ? pw : pr) != 0 && nb > 1) ? 1 : 0;
    if (pok == 0) acc = nb;
    else begin
      acc = 1;
      for (int i = 1; i < nb; i++)
        if ((beat_addr(base, i, bbl, tl, wrap) >> (4 + psel)) !=
            (beat_addr(base, i - 1, bbl, tl, wrap) >> (4 + psel))) acc++;
    end
    gap    = (d != 0) ? d : ((wr != 0) ? 0 : 1);
    expcyc = acc * (1 + gap) + nb * (w + 1);
    wmask  = (bbl == 0) ? 16'h00FF : 16'hFFFF;

    @(negedge clk);
    check(req_ready === 1'b1 && done === 1'b0, "R11", "idle before request",
          {req_ready, done}, 2'b10);
    cfg_bus16 = bus[0]; cfg_page_sel = psel[1:0]; cfg_wait = w[3:0];
    cfg_cs_delay = d[3:0]; cfg_page_rd_en = pr[0]; cfg_page_wr_en = pw[0];
    req_addr = base; req_size = size[1:0]; req_len_log2 = len[1:0];
    req_wrap = wrap[0]; req_write = wr[0]; wr_word = word_f(0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    k = 0; r = 0; pops = 0; falls = 0; cyc = 0; busy_bad = 0;
    addr_bad = 0; rd_bad = 0; wd_bad = 0; prev_cs = 1'b1;
    bad_a = '0; bad_e = '0;
    while (done !== 1'b1 && cyc < 4000) begin
      if (req_ready !== 1'b0) busy_bad++;
      if (prev_cs && !ext_cs_n) falls++;
      prev_cs = ext_cs_n;
      if (!ext_rd_n || !ext_wr_n) begin
        ea = beat_addr(base, k, bbl, tl, wrap);
        if (ext_addr !== ea) begin
          if (addr_bad == 0) begin bad_a = ext_addr; bad_e = ea; end
          addr_bad++;
        end
        if (!ext_wr_n) begin
          wexp = 16'(word_f(k >> (size - bbl)) >> (8 * (ea & 16'(sb - 1)))) & wmask;
          if ((ext_wdata & wmask) !== wexp) begin
            if (wd_bad == 0) $display("FAIL R10 write lane beat %0d actual=%0h expected=%0h",
                                      k, ext_wdata & wmask, wexp);
            wd_bad++;
          end
        end
        k++;
      end
      if (rd_valid) begin
        if (rd_data !== mem_f(beat_addr(base, r, bbl, tl, wrap))) rd_bad++;
        r++;
      end
      if (wr_pop) begin
        pops++;
        wr_word = word_f(pops);
      end
      cyc++;
      @(negedge clk);
    end

    tag_adr = (wrap != 0) ? "R3" : "R2";
    tag_acc = (pok == 0) ? "R6" : ((acc > 1) ? "R5" : "R4");
    tag_cyc = (d != 0 || wr == 0) ? "R8" : "R7";
    check(cyc < 4000, "R11", "done reached", cyc, expcyc);
    check(k == nb, tag_adr, "beat count", k, nb);
    check(addr_bad == 0, tag_adr, "beat address", bad_a, bad_e);
    check(falls == acc, tag_acc, "access count", falls, acc);
    check(cyc == expcyc, tag_cyc, "busy cycles", cyc, expcyc);
    check(busy_bad == 0, "R11", "ready low while busy", busy_bad, 0);
    if (wr == 0) begin
      check(r == nb, "R9", "read beats returned", r, nb);
      check(rd_bad == 0, "R9", "read data", rd_bad, 0);
    end else begin
      check(wd_bad == 0, "R10", "write lanes", wd_bad, 0);
      check(pops == (1 << len), "R10", "pop count", pops, 1 << len);
      check(r == 0, "R9", "no read data on write", r, 0);
    end
  endtask

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ext_cs_n === 1'b1, "R1", "cs after reset", ext_cs_n, 1);
    check(ext_rd_n === 1'b1 && ext_wr_n === 1'b1, "R1", "strobes after reset",
          {ext_rd_n, ext_wr_n}, 2'b11);
    check(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done after reset",
          {req_ready, done}, 2'b10);

    idx = 0;
    for (int bus = 0; bus < 2; bus++)
      for (int size = 0; size < 3; size++)
        for (int len = 0; len < 4; len++)
          for (int wrap = 0; wrap < 2; wrap++)
            for (int wr = 0; wr < 2; wr++)
              for (int v = 0; v < 4; v++) begin
                logic [15:0] base;
                base = 16'h0200 + 16'((idx * 7) & 8'h3F);
                case (v)
                  0: run_txn(size, len, wrap, wr, bus, 0, 0, 0, 1, 1, base);
                  1: run_txn(size, len, wrap, wr, bus, 1, 2, 1, 1, 1, base);
                  2: run_txn(size, len, wrap, wr, bus, 0, 1, 3, 0, 0, base);
                  default: run_txn(size, len, wrap, wr, bus, 0, 0, 2, 1, 0, base);
                endcase
                idx++;
              end

    @(negedge clk);
    check(done === 1'b0, "R11", "done single cycle", done, 0);
    finish_run();
  end
endmodule